// File: doc/BRIEF.md
# Text-Mode Character Display Generator

This block turns a character-cell text screen into pixel data. The screen is 80 cells across and 25 cells down, 2000 cells in all. For every cell the block holds a character code and an attribute byte in two separate planes. A third plane, the font plane, holds 256 glyphs of 8 by 16 pixels. A host processor loads all three planes and the cursor position through a single byte-wide write port. A region select on that port picks a character cell, an attribute cell, a font byte or the cursor register pair.

On the raster side, an external timing generator presents a horizontal and a vertical pixel counter every clock. Three clocks later the block returns one pixel bit and the attribute byte of the cell under that pixel, for a palette stage further down. Outside the 640 by 400 pixel text area both outputs are zero. A cursor can be placed at any linear cell offset. It is drawn as a solid bar over the two lowest scanlines of its cell and blinks under control of a frame pulse. Sync generation, colour lookup and scrolling are handled elsewhere. Software scrolls by rewriting the planes.

Top module: `txtgen_top`

## Requirements
- R1: While reset is held, and on the first clock after it, `pix_on` is 0 and `pix_attr` is 0.
- R2: For a pixel inside the text area, `pix_on` equals bit (7 - hcnt mod 8) of font row (vcnt mod 16) of the glyph for the character code at cell (vcnt div 16)*80 + (hcnt div 8). Bit 7 is the leftmost pixel.
- R3: For a pixel inside the text area, `pix_attr` equals the attribute byte stored for that cell, unchanged.
- R4: `pix_on` and `pix_attr` reflect the `hcnt`/`vcnt` values sampled three rising clock edges earlier, and a new pixel is accepted every clock.
- R5: In the font region (`cpu_sel`=2), byte address code*32 + r writes glyph row r of that code for r in 0..15. Addresses whose bit 4 is 1 (rows 16..31 of a slot) are ignored.
- R6: A pixel with `hcnt` >= 640 or `vcnt` >= 400 gives `pix_on`=0 and `pix_attr`=0.
- R7: In the cursor-register region (`cpu_sel`=3), a write with `cpu_addr[0]`=0 selects a register index. A write with `cpu_addr[0]`=1 loads the selected register: index 14 sets the high byte of the 16-bit cursor offset, and index 15 sets the low byte. Data writes to any other index leave the cursor unchanged.
- R8: When the cursor is visible, every pixel of scanlines 14 and 15 of the cell whose linear index equals the cursor offset is on. The cursor changes no other scanline and no other cell.
- R9: Cursor visibility depends on the count of `frame_tick` pulses since reset. The cursor is visible while (count mod 32) < 16 and hidden otherwise.
- R10: After reset the cursor offset is 0xFFFF, so no cell shows a cursor until it is programmed.
- R11: Character (`cpu_sel`=0) and attribute (`cpu_sel`=1) writes store a byte at cell index `cpu_addr` when it is below 2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Write strobe of the host port |
| cpu_sel | input | 2 | Region: 0 character, 1 attribute, 2 font, 3 cursor registers |
| cpu_addr | input | 13 | Byte address within the region |
| cpu_wdata | input | 8 | Write data |
| frame_tick | input | 1 | One-clock pulse per frame, drives cursor blink |
| hcnt | input | 10 | Horizontal pixel counter |
| vcnt | input | 10 | Vertical pixel counter |
| pix_on | output | 1 | Foreground pixel bit |
| pix_attr | output | 8 | Attribute byte of the cell, aligned with `pix_on` |

## Verification
The hardest state to reach is the cursor cell during its hidden blink phase. A correct result there depends on four things at once: the two-register cursor load, an exact count of frame pulses, the two lowest scanlines, and font rows that a stray write into an unused slot row could corrupt. The stimulus programs a known cell with a known glyph and places the cursor on it through the index/data pair. It issues a write to an unrelated index, then sends exactly 16 frame pulses and later 16 more, probing both cursor scanlines each time. Around these directed steps, long runs of random coordinates stream one pixel per clock over fully random planes. Some runs are focused on the cursor neighbourhood and some reach past the text area.

// File: rtl/txtgen_pkg.sv
// Shared constants and types for the text-mode display generator.
// Assumes a fixed glyph geometry of 8 by 16 pixels stored on a 32-byte slot stride.
package txtgen_pkg;
    localparam int GLYPH_W    = 8;
    localparam int GLYPH_H    = 16;
    localparam int GLYPHS     = 256;
    localparam int SLOT_BYTES = 32;
    localparam int CODE_W     = $clog2(GLYPHS);
    localparam int ROW_W      = $clog2(GLYPH_H);
    localparam int SLOT_W     = $clog2(SLOT_BYTES);
    localparam int XBIT_W     = $clog2(GLYPH_W);
    localparam int FONT_DEPTH = GLYPHS * GLYPH_H;
    localparam int FONT_AW    = $clog2(FONT_DEPTH);
    localparam int HOST_AW    = CODE_W + SLOT_W;
    localparam logic [7:0] CUR_HI_IDX = 8'd14;
    localparam logic [7:0] CUR_LO_IDX = 8'd15;

    typedef enum logic [1:0] {
        SEL_CHAR = 2'd0,
        SEL_ATTR = 2'd1,
        SEL_FONT = 2'd2,
        SEL_CRT  = 2'd3
    } host_sel_e;
endpackage

// File: rtl/txtgen_cell_store.sv
// Character and attribute planes, one generated memory per plane.
// Assumes one host write port and one synchronous raster read port per plane.
// The memories carry no reset; their contents are undefined until written.
module txtgen_cell_store #(
    parameter int DEPTH  = 2000,
    parameter int AW     = $clog2(DEPTH),
    parameter int DW     = 8,
    parameter int PLANES = 2
) (
    input  logic                       clk,
    input  logic [PLANES-1:0]          we,
    input  logic [AW-1:0]              waddr,
    input  logic [DW-1:0]              wdata,
    input  logic [AW-1:0]              raddr,
    output logic [PLANES-1:0][DW-1:0]  rdata
);
    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        logic [DW-1:0] mem [DEPTH];
        logic [DW-1:0] q;

        // Host write and registered raster read of this plane
        always_ff @(posedge clk) begin
            if (we[p]) mem[waddr] <= wdata;
            q <= mem[raddr];
        end

        assign rdata[p] = q;
    end
endmodule

// File: rtl/txtgen_font_store.sv
// Font plane: keeps the 16 live rows of each glyph slot, drops the unused rows.
// Assumes host byte address = code*SLOT_BYTES + row; raster reads are synchronous.
module txtgen_font_store
    import txtgen_pkg::*;
(
    input  logic                clk,
    input  logic                we,
    input  logic [HOST_AW-1:0]  waddr,
    input  logic [7:0]          wdata,
    input  logic [CODE_W-1:0]   rcode,
    input  logic [ROW_W-1:0]    rrow,
    output logic [7:0]          rdata
);
    logic [7:0]         mem [FONT_DEPTH];
    logic               row_live;
    logic [FONT_AW-1:0] wslot;

    // A row address is live only when the bits above the row field within the slot are zero
    always_comb begin
        row_live = (waddr[SLOT_W-1:ROW_W] == '0);
        wslot    = {waddr[HOST_AW-1:SLOT_W], waddr[ROW_W-1:0]};
    end

    // Host glyph write and registered raster glyph-row read
    always_ff @(posedge clk) begin
        if (we && row_live) mem[wslot] <= wdata;
        rdata <= mem[{rcode, rrow}];
    end
endmodule

// File: rtl/txtgen_cursor_ctl.sv
// Cursor register pair behind an index/data port, plus the frame-based blink phase.
// Assumes port bit 0 low selects the index port and high selects the data port.
module txtgen_cursor_ctl
    import txtgen_pkg::*;
#(
    parameter int          BLINK_W   = 5,
    parameter logic [15:0] RESET_OFF = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic        port_data,
    input  logic [7:0]  wdata,
    input  logic        frame_tick,
    output logic [7:0]  crt_idx,
    output logic [15:0] cur_off,
    output logic        blink_vis
);
    logic [BLINK_W-1:0] frame_cnt;

    // Index latch and the two cursor offset bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crt_idx <= '0;
            cur_off <= RESET_OFF;
        end else if (we && !port_data) begin
            crt_idx <= wdata;
        end else if (we && port_data) begin
            if (crt_idx == CUR_HI_IDX) cur_off[15:8] <= wdata;
            if (crt_idx == CUR_LO_IDX) cur_off[7:0]  <= wdata;
        end
    end

    // Free-running frame count for the blink cycle
    always_ff @(posedge clk) begin
        if (!rst_n)          frame_cnt <= '0;
        else if (frame_tick) frame_cnt <= frame_cnt + 1'b1;
    end

    // Cursor shown during the first half of the blink cycle
    always_comb blink_vis = ~frame_cnt[BLINK_W-1];
endmodule

// File: rtl/txtgen_top.sv
// Text-mode display generator: three-stage raster pipeline over cell, font and cursor state.
// Stage 1 reads the cell planes, stage 2 reads the glyph row, stage 3 registers the outputs.
// Assumes hcnt/vcnt arrive from an external timing generator, one pixel per clock.
module txtgen_top
    import txtgen_pkg::*;
#(
    parameter int COLS    = 80,
    parameter int ROWS    = 25,
    parameter int CNT_W   = 10,
    parameter int BLINK_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_we,
    input  logic [1:0]          cpu_sel,
    input  logic [HOST_AW-1:0]  cpu_addr,
    input  logic [7:0]          cpu_wdata,
    input  logic                frame_tick,
    input  logic [CNT_W-1:0]    hcnt,
    input  logic [CNT_W-1:0]    vcnt,
    output logic                pix_on,
    output logic [7:0]          pix_attr
);
    localparam int CELLS   = COLS * ROWS;
    localparam int CELL_AW = $clog2(CELLS);
    localparam int ACT_W   = COLS * GLYPH_W;
    localparam int ACT_H   = ROWS * GLYPH_H;
    localparam int CUR_ROW = GLYPH_H - 2;

    logic [7:0]  crt_idx;
    logic [15:0] cur_off;
    logic        blink_vis;

    // ---- stage 0: address generation ----
    logic               in_area;
    int                 cell_i;
    logic [CELL_AW-1:0] cell_raddr;
    logic [ROW_W-1:0]   scan0;
    logic [XBIT_W-1:0]  xbit0;
    logic               cur_hit0;

    // Map pixel counters to a cell index, scanline and pixel column
    always_comb begin
        in_area    = (int'(hcnt) < ACT_W) && (int'(vcnt) < ACT_H);
        cell_i     = (int'(vcnt) / GLYPH_H) * COLS + (int'(hcnt) / GLYPH_W);
        cell_raddr = in_area ? CELL_AW'(cell_i) : '0;
        scan0      = vcnt[ROW_W-1:0];
        xbit0      = hcnt[XBIT_W-1:0];
        cur_hit0   = blink_vis && (int'(cur_off) == cell_i) && (int'(scan0) >= CUR_ROW);
    end

    // ---- host write decode ----
    logic [1:0]    cell_we;
    logic          font_we;

    // Route the host strobe to the selected plane, bounding cell writes
    always_comb begin
        cell_we[0] = cpu_we && (cpu_sel == SEL_CHAR) && (int'(cpu_addr) < CELLS);
        cell_we[1] = cpu_we && (cpu_sel == SEL_ATTR) && (int'(cpu_addr) < CELLS);
        font_we    = cpu_we && (cpu_sel == SEL_FONT);
    end

    logic [1:0][7:0] cell_q;

    txtgen_cell_store #(
        .DEPTH  (CELLS),
        .AW     (CELL_AW),
        .DW     (8),
        .PLANES (2)
    ) u_cells (
        .clk   (clk),
        .we    (cell_we),
        .waddr (cpu_addr[CELL_AW-1:0]),
        .wdata (cpu_wdata),
        .raddr (cell_raddr),
        .rdata (cell_q)
    );

    txtgen_cursor_ctl #(
        .BLINK_W   (BLINK_W),
        .RESET_OFF (16'hFFFF)
    ) u_cur (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cpu_we && (cpu_sel == SEL_CRT)),
        .port_data  (cpu_addr[0]),
        .wdata      (cpu_wdata),
        .frame_tick (frame_tick),
        .crt_idx    (crt_idx),
        .cur_off    (cur_off),
        .blink_vis  (blink_vis)
    );

    // ---- stage 1 ----
    logic              s1_area;
    logic [ROW_W-1:0]  s1_scan;
    logic [XBIT_W-1:0] s1_xbit;
    logic              s1_cur;

    // Carry pixel position alongside the cell-plane read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_area <= 1'b0;
            s1_scan <= '0;
            s1_xbit <= '0;
            s1_cur  <= 1'b0;
        end else begin
            s1_area <= in_area;
            s1_scan <= scan0;
            s1_xbit <= xbit0;
            s1_cur  <= in_area && cur_hit0;
        end
    end

    logic [7:0] glyph_q;

    txtgen_font_store u_font (
        .clk   (clk),
        .we    (font_we),
        .waddr (cpu_addr),
        .wdata (cpu_wdata),
        .rcode (cell_q[0]),
        .rrow  (s1_scan),
        .rdata (glyph_q)
    );

    // ---- stage 2 ----
    logic              s2_area;
    logic [XBIT_W-1:0] s2_xbit;
    logic              s2_cur;
    logic [7:0]        s2_attr;

    // Carry attribute and cursor flag alongside the glyph read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_area <= 1'b0;
            s2_xbit <= '0;
            s2_cur  <= 1'b0;
            s2_attr <= '0;
        end else begin
            s2_area <= s1_area;
            s2_xbit <= s1_xbit;
            s2_cur  <= s1_cur;
            s2_attr <= cell_q[1];
        end
    end

    // ---- stage 3: output register ----
    logic glyph_bit;

    // Select the pixel of the glyph row, leftmost pixel in the top bit
    always_comb glyph_bit = glyph_q[(GLYPH_W - 1) - int'(s2_xbit)];

    // Register pixel and attribute, blanking outside the text area
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_on   <= 1'b0;
            pix_attr <= '0;
        end else begin
            pix_on   <= s2_area && (glyph_bit || s2_cur);
            pix_attr <= s2_area ? s2_attr : '0;
        end
    end
endmodule

// File: rtl/txtgen_chk.sv
// Property checker for txtgen_top, attached by bind.
// Assumes the default 80x25 geometry for the blanking limits.
module txtgen_chk
    import txtgen_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_we,
    input logic [1:0]  cpu_sel,
    input logic [12:0] cpu_addr,
    input logic        frame_tick,
    input logic [9:0]  hcnt,
    input logic [9:0]  vcnt,
    input logic        pix_on,
    input logic [7:0]  pix_attr,
    input logic [7:0]  crt_idx,
    input logic [15:0] cur_off,
    input logic        blink_vis
);
    localparam int LIM_H = 640;
    localparam int LIM_V = 400;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!pix_on && pix_attr == 8'h00)); // R1

    AST_BLANK_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        (int'($past(hcnt, 3)) >= LIM_H || int'($past(vcnt, 3)) >= LIM_V) |-> !pix_on); // R6

    AST_BLANK_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
        (int'($past(hcnt, 3)) >= LIM_H || int'($past(vcnt, 3)) >= LIM_V) |-> pix_attr == 8'h00); // R6

    AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(blink_vis)); // R9

    AST_CRT_OTHER_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_sel == SEL_CRT && cpu_addr[0] &&
         crt_idx != CUR_HI_IDX && crt_idx != CUR_LO_IDX) |=> $stable(cur_off)); // R7

    AST_CRT_INDEX_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_sel == SEL_CRT && !cpu_addr[0]) |=> $stable(cur_off)); // R7
endmodule

bind txtgen_top txtgen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_we     (cpu_we),
    .cpu_sel    (cpu_sel),
    .cpu_addr   (cpu_addr),
    .frame_tick (frame_tick),
    .hcnt       (hcnt),
    .vcnt       (vcnt),
    .pix_on     (pix_on),
    .pix_attr   (pix_attr),
    .crt_idx    (crt_idx),
    .cur_off    (cur_off),
    .blink_vis  (blink_vis)
);

// File: tb/txtgen_top_tb.sv
// Self-checking bench for txtgen_top: random planes, streamed random pixels, directed cursor cases.
module txtgen_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_sel = 2'd0;
    logic [12:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        frame_tick = 1'b0;
    logic [9:0]  hcnt = '0;
    logic [9:0]  vcnt = '0;
    logic        pix_on;
    logic [7:0]  pix_attr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txtgen_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_we     (cpu_we),
        .cpu_sel    (cpu_sel),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .frame_tick (frame_tick),
        .hcnt       (hcnt),
        .vcnt       (vcnt),
        .pix_on     (pix_on),
        .pix_attr   (pix_attr)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference state built only from the requirements
    logic [7:0]  m_char [2000];
    logic [7:0]  m_attr [2000];
    logic [7:0]  m_font [4096];
    logic [15:0] m_cur = 16'hFFFF;
    logic [7:0]  m_idx = 8'h00;
    int          m_frames = 0;

    localparam int CUR_CELL = 15 * 80 + 34;
    localparam int CODE_A   = 8'h41;

    function automatic logic exp_pix(int h, int v);
        int idx, sc, x;
        logic [7:0] g;
        logic cur;
        if (h >= 640 || v >= 400) return 1'b0;
        idx = (v / 16) * 80 + h / 8;
        sc  = v % 16;
        x   = h % 8;
        g   = m_font[int'(m_char[idx]) * 16 + sc];
        cur = (int'(m_cur) == idx) && (sc >= 14) && (((m_frames / 16) % 2) == 0);
        return g[7 - x] | cur;
    endfunction

    function automatic logic [7:0] exp_attr(int h, int v);
        if (h >= 640 || v >= 400) return 8'h00;
        return m_attr[(v / 16) * 80 + h / 8];
    endfunction

    function automatic string pix_tag(int h, int v);
        if (h >= 640 || v >= 400) return "R6 blank";
        if ((v % 16) >= 14 && m_cur == 16'hFFFF) return "R10 no cursor";
        if ((v % 16) >= 14 && ((v / 16) * 80 + h / 8) == int'(m_cur)) return "R8 R9 cursor";
        return "R2 R4 pixel";
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at h=%0d v=%0d", req, act, exp, hcnt, vcnt);
        end
    endtask

    // One host write, mirrored into the reference state
    task automatic wr(logic [1:0] sel, int addr, logic [7:0] data);
        @(negedge clk);
        cpu_we = 1'b1; cpu_sel = sel; cpu_addr = 13'(addr); cpu_wdata = data;
        @(negedge clk);
        cpu_we = 1'b0;
        case (sel)
            2'd0: if (addr < 2000) m_char[addr] = data;
            2'd1: if (addr < 2000) m_attr[addr] = data;
            2'd2: if (((addr >> 4) & 1) == 0) m_font[(addr / 32) * 16 + (addr % 16)] = data;
            default: begin
                if ((addr & 1) == 0) m_idx = data;
                else if (m_idx == 8'd14) m_cur[15:8] = data;
                else if (m_idx == 8'd15) m_cur[7:0] = data;
            end
        endcase
    endtask

    task automatic tick();
        @(negedge clk);
        frame_tick = 1'b1;
        m_frames++;
        @(negedge clk);
        frame_tick = 1'b0;
    endtask

    // Stream one coordinate per clock and compare three clocks later (R4)
    task automatic stream(int n, int mode);
        int hh[4], vv[4];
        for (int i = 0; i < n + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                check(pix_tag(hh[(i - 3) % 4], vv[(i - 3) % 4]), {7'b0, pix_on},
                      {7'b0, exp_pix(hh[(i - 3) % 4], vv[(i - 3) % 4])});
                check("R3 attr", pix_attr, exp_attr(hh[(i - 3) % 4], vv[(i - 3) % 4]));
            end
            if (i < n) begin
                if (mode == 0) begin
                    hh[i % 4] = $urandom_range(0, 799);
                    vv[i % 4] = $urandom_range(0, 524);
                end else begin
                    hh[i % 4] = 34 * 8 - 8 + $urandom_range(0, 23);
                    vv[i % 4] = 15 * 16 - 2 + $urandom_range(0, 19);
                end
                hcnt = 10'(hh[i % 4]);
                vcnt = 10'(vv[i % 4]);
            end
        end
    endtask

    task automatic point(int h, int v, string req);
        @(negedge clk);
        hcnt = 10'(h); vcnt = 10'(v);
        repeat (3) @(negedge clk);
        check(req, {7'b0, pix_on}, {7'b0, exp_pix(h, v)});
        check(req, pix_attr, exp_attr(h, v));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: outputs held clear in reset and on the first edge after it
        repeat (4) @(negedge clk);
        check("R1 reset pix", {7'b0, pix_on}, 8'h00);
        check("R1 reset attr", pix_attr, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset pix", {7'b0, pix_on}, 8'h00);
        check("R1 post-reset attr", pix_attr, 8'h00);

        // R11 / R5: fill every plane with random content
        for (int a = 0; a < 2000; a++) wr(2'd0, a, 8'($urandom()));
        for (int a = 0; a < 2000; a++) wr(2'd1, a, 8'($urandom()));
        for (int c = 0; c < 256; c++)
            for (int r = 0; r < 16; r++) wr(2'd2, c * 32 + r, 8'($urandom()));
        // R5: junk into unused slot rows must not reach the glyphs
        for (int k = 0; k < 64; k++) wr(2'd2, $urandom_range(0, 255) * 32 + 16 + $urandom_range(0, 15), 8'($urandom()));
        // R11: out-of-range cell writes are dropped
        wr(2'd0, 2000 + 5, 8'hEE);
        wr(2'd1, 8191, 8'hEE);

        // R10: cursor still parked off-screen
        stream(3000, 0);

        // Directed corners of the text area (R2, R6)
        point(0, 0, "R2 first pixel");
        point(639, 399, "R2 last pixel");
        point(640, 0, "R6 right edge");
        point(0, 400, "R6 bottom edge");
        point(1023, 1023, "R6 far corner");

        // R7: program the cursor through the index/data pair
        wr(2'd0, CUR_CELL, 8'(CODE_A));
        wr(2'd2, CODE_A * 32 + 14, 8'h00);
        wr(2'd2, CODE_A * 32 + 15, 8'h81);
        wr(2'd3, 0, 8'd14);
        wr(2'd3, 1, 8'(CUR_CELL >> 8));
        wr(2'd3, 0, 8'd15);
        wr(2'd3, 1, 8'(CUR_CELL & 8'hFF));
        wr(2'd3, 0, 8'd3);
        wr(2'd3, 1, 8'h00);
        for (int x = 0; x < 8; x++) point(34 * 8 + x, 15 * 16 + 14, "R7 R8 cursor row 14");
        point(34 * 8 + 3, 15 * 16 + 15, "R8 cursor row 15");
        point(34 * 8 + 3, 15 * 16 + 13, "R8 row above cursor");
        point(35 * 8 + 3, 15 * 16 + 14, "R8 neighbour cell");
        stream(1500, 1);

        // R9: hidden after 16 frame pulses
        repeat (16) tick();
        // R5: write into the unused row that aliases row 14 of CODE_A
        wr(2'd2, CODE_A * 32 + 16 + 14, 8'hFF);
        for (int x = 0; x < 8; x++) point(34 * 8 + x, 15 * 16 + 14, "R5 R9 hidden cursor");
        stream(800, 1);
        // R9: visible again after 16 more
        repeat (16) tick();
        point(34 * 8 + 2, 15 * 16 + 14, "R9 cursor back");
        stream(1500, 1);
        stream(2000, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: an expired run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule